// File: doc/BRIEF.md
# Three-Phase Commutation Output Mapper

This block sits between a motor-control PWM generator and the six gate-driver outputs of a three-phase bridge. Each phase has an A output and a B output. In block-commutation mode one PWM waveform, the A waveform of phase 0, is routed to any subset of the six outputs. A 6-bit commutation pattern selects that subset. Outputs left out of the pattern rest at a passive level, and a polarity input chooses that level. An option flips all three B outputs after masking, for bridge drivers whose low-side inputs are active low. In this mode the B outputs are not forced to be the complement of the A outputs.

Software writes the pattern into a shadow register. The active pattern, which drives the outputs, takes the shadow value only when the PWM generator pulses its cycle-start strobe, so a commutation step never lands in the middle of a PWM period. When block-commutation mode is off, the six normal per-channel outputs of the PWM generator pass through unchanged.

Top module: `bldc_commute_map`

## Requirements
- R1: After reset the shadow pattern and the active pattern are both 0. With the mode enabled, every output therefore sits at its passive level.
- R2: A cycle with `pat_wr_en` high loads `pat_wr_data` into the shadow pattern, and `pat_rd_data` shows it from the next cycle on. The active pattern does not change unless `cycle_start` is high.
- R3: A cycle with `cycle_start` high and no write copies the shadow pattern into the active pattern, and `pat_active` shows it from the next cycle on.
- R4: When a write and `cycle_start` fall in the same cycle, the active pattern takes the newly written value, not the old shadow value.
- R5: With `mode_en` high, every output whose active pattern bit is 1 equals `pwm_wave` (before the B inversion of R7).
- R6: With `mode_en` high, every output whose active pattern bit is 0 equals `idle_level`. A value of 0 gives a low passive level.
- R7: With `mode_en` high and `b_invert` high, each B output is the inverse of its masked value. The A outputs are unaffected. With `b_invert` low, the B outputs keep the polarity of the A outputs.
- R8: With `mode_en` low, `drv_a` equals `norm_a` and `drv_b` equals `norm_b`, whatever the pattern, `b_invert`, `idle_level` or `pwm_wave` may be.
- R9: Pattern bit 2k controls phase k's A output and bit 2k+1 controls phase k's B output. For example, the value 6'b110101 makes A0, A1, A2 and B2 follow the PWM waveform, while B0 and B1 stay passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pat_wr_en | input | 1 | Write strobe for the shadow pattern |
| pat_wr_data | input | 6 | Pattern value to write |
| pat_rd_data | output | 6 | Current shadow pattern |
| pat_active | output | 6 | Current active pattern |
| cycle_start | input | 1 | Pulse at the start of each PWM cycle |
| mode_en | input | 1 | Enables block-commutation mapping |
| b_invert | input | 1 | Inverts the three B outputs in commutation mode |
| idle_level | input | 1 | Passive level for masked outputs |
| pwm_wave | input | 1 | Phase-0 A PWM waveform to be steered |
| norm_a | input | 3 | Normal A outputs, one per phase |
| norm_b | input | 3 | Normal B outputs, one per phase |
| drv_a | output | 3 | A outputs to the bridge driver |
| drv_b | output | 3 | B outputs to the bridge driver |

## Verification
A pattern write and a cycle-start strobe can land in the same clock cycle. In that case the shadow update and the shadow-to-active transfer meet. The bench provokes this by raising both strobes on one edge while the shadow holds a different older value. It then judges that the active pattern shows the new value on the following cycle, not the stale one. It also writes without a strobe and strobes without a write, to confirm that each event on its own moves only its own register.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  // Level of one output lane in commutation mode, before any B inversion.
  function automatic logic lane_level(input logic sel, input logic wave, input logic idle);
    return sel ? wave : idle;
  endfunction

  // Next active pattern: a write in the same cycle as the strobe wins.
  function automatic logic [7:0] next_shadow(input logic wr, input logic [7:0] wdata,
                                             input logic [7:0] cur);
    return wr ? wdata : cur;
  endfunction
endpackage

// File: rtl/bcm_pattern_regs.sv
module bcm_pattern_regs #(
  parameter int PAT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PAT_W-1:0] wr_data,
  input  logic             cycle_start,
  output logic [PAT_W-1:0] shadow_q,
  output logic [PAT_W-1:0] active_q
);
  import bcm_pkg::*;

  logic [PAT_W-1:0] shadow_nxt;
  logic [7:0]       shadow_wide;

  always_comb begin
    shadow_wide = next_shadow(wr_en, 8'(wr_data), 8'(shadow_q));
    shadow_nxt  = shadow_wide[PAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_nxt;
      if (cycle_start) active_q <= shadow_nxt;
    end
  end

  // R2: a write lands in the shadow copy
  a_r2_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> shadow_q == $past(wr_data));
  // R2: no strobe, no change of the active copy
  a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(active_q));
  // R3: strobe alone transfers the old shadow
  a_r3_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !wr_en) |=> active_q == $past(shadow_q));
  // R4: strobe together with a write takes the new data
  a_r4_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && wr_en) |=> active_q == $past(wr_data));
endmodule

// File: rtl/bcm_lane_mux.sv
module bcm_lane_mux #(
  parameter int NUM_PH = 3,
  localparam int PAT_W = 2 * NUM_PH
) (
  input  logic              mode_en,
  input  logic              b_invert,
  input  logic              idle_level,
  input  logic              wave,
  input  logic [PAT_W-1:0]  active_pat,
  input  logic [NUM_PH-1:0] norm_a,
  input  logic [NUM_PH-1:0] norm_b,
  output logic [NUM_PH-1:0] drv_a,
  output logic [NUM_PH-1:0] drv_b
);
  import bcm_pkg::*;

  logic [NUM_PH-1:0] masked_a;
  logic [NUM_PH-1:0] masked_b;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
    always_comb begin
      masked_a[k] = lane_level(active_pat[2*k],   wave, idle_level);
      masked_b[k] = lane_level(active_pat[2*k+1], wave, idle_level) ^ b_invert;
      drv_a[k]    = mode_en ? masked_a[k] : norm_a[k];
      drv_b[k]    = mode_en ? masked_b[k] : norm_b[k];
    end
  end
endmodule

// File: rtl/bldc_commute_map.sv
module bldc_commute_map #(
  parameter int NUM_PH = 3,
  localparam int PAT_W = 2 * NUM_PH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_wr_en,
  input  logic [PAT_W-1:0]  pat_wr_data,
  output logic [PAT_W-1:0]  pat_rd_data,
  output logic [PAT_W-1:0]  pat_active,
  input  logic              cycle_start,
  input  logic              mode_en,
  input  logic              b_invert,
  input  logic              idle_level,
  input  logic              pwm_wave,
  input  logic [NUM_PH-1:0] norm_a,
  input  logic [NUM_PH-1:0] norm_b,
  output logic [NUM_PH-1:0] drv_a,
  output logic [NUM_PH-1:0] drv_b
);
  logic [PAT_W-1:0] shadow_pat;
  logic [PAT_W-1:0] live_pat;

  bcm_pattern_regs #(.PAT_W(PAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(pat_wr_en), .wr_data(pat_wr_data),
    .cycle_start(cycle_start), .shadow_q(shadow_pat), .active_q(live_pat)
  );

  bcm_lane_mux #(.NUM_PH(NUM_PH)) u_mux (
    .mode_en(mode_en), .b_invert(b_invert), .idle_level(idle_level),
    .wave(pwm_wave), .active_pat(live_pat), .norm_a(norm_a), .norm_b(norm_b),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  assign pat_rd_data = shadow_pat;
  assign pat_active  = live_pat;

  // R8: bypass when the mode is off
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> (drv_a == norm_a && drv_b == norm_b));

  for (genvar k = 0; k < NUM_PH; k++) begin : g_chk
    // R5, R9: selected A lane follows the waveform
    a_r5_a_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && live_pat[2*k]) |-> drv_a[k] == pwm_wave);
    // R6, R9: unselected A lane rests at passive level
    a_r6_a_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && !live_pat[2*k]) |-> drv_a[k] == idle_level);
    // R7: B lane inversion after masking
    a_r7_b_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && b_invert && !live_pat[2*k+1]) |-> drv_b[k] == !idle_level);
    // R5: selected B lane without inversion follows the waveform
    a_r5_b_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && !b_invert && live_pat[2*k+1]) |-> drv_b[k] == pwm_wave);
  end
endmodule

// File: tb/test_bldc_commute_map.sv
module test_bldc_commute_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pat_wr_en = 1'b0;
  logic [5:0] pat_wr_data = '0;
  logic [5:0] pat_rd_data, pat_active;
  logic       cycle_start = 1'b0;
  logic       mode_en = 1'b0, b_invert = 1'b0, idle_level = 1'b0, pwm_wave = 1'b0;
  logic [2:0] norm_a = '0, norm_b = '0;
  logic [2:0] drv_a, drv_b;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bldc_commute_map i_bldc_commute_map (
    .clk(clk), .rst_n(rst_n), .pat_wr_en(pat_wr_en), .pat_wr_data(pat_wr_data),
    .pat_rd_data(pat_rd_data), .pat_active(pat_active), .cycle_start(cycle_start),
    .mode_en(mode_en), .b_invert(b_invert), .idle_level(idle_level),
    .pwm_wave(pwm_wave), .norm_a(norm_a), .norm_b(norm_b),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  task automatic check6(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Expected {B2,B1,B0,A2,A1,A0} restated from the lane rules.
  function automatic logic [5:0] model(input logic [5:0] pat);
    logic [5:0] r;
    if (!mode_en) return {norm_b, norm_a};
    for (int k = 0; k < 3; k++) begin
      r[k]   = pat[2*k]   ? pwm_wave : idle_level;
      r[k+3] = (pat[2*k+1] ? pwm_wave : idle_level) ^ b_invert;
    end
    return r;
  endfunction

  task automatic check_outs(input string req);
    #2;
    check6(req, {drv_b, drv_a}, model(pat_active));
  endtask

  task automatic wr_pat(input logic [5:0] v, input logic strobe);
    @(negedge clk);
    pat_wr_en = 1'b1; pat_wr_data = v; cycle_start = strobe;
    @(negedge clk);
    pat_wr_en = 1'b0; cycle_start = 1'b0;
  endtask

  task automatic strobe_only();
    @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
  endtask

  task automatic t_reset();
    mode_en = 1'b1; idle_level = 1'b0;
    #2;
    check6("R1 shadow", pat_rd_data, 6'b0);
    check6("R1 active", pat_active, 6'b0);
    check6("R1 outputs low", {drv_b, drv_a}, 6'b000000);
    idle_level = 1'b1; pwm_wave = 1'b0;
    #2;
    check6("R1 outputs high", {drv_b, drv_a}, 6'b111111);
    idle_level = 1'b0;
  endtask

  task automatic t_shadow_then_transfer();
    wr_pat(6'b101010, 1'b0);
    check6("R2 readback", pat_rd_data, 6'b101010);
    check6("R2 active held", pat_active, 6'b000000);
    repeat (3) @(negedge clk);
    check6("R2 active still held", pat_active, 6'b000000);
    strobe_only();
    check6("R3 transfer", pat_active, 6'b101010);
  endtask

  task automatic t_collide();
    wr_pat(6'b000011, 1'b0);
    wr_pat(6'b011100, 1'b1);
    check6("R4 new value wins", pat_active, 6'b011100);
    check6("R4 shadow", pat_rd_data, 6'b011100);
  endtask

  task automatic t_example();
    mode_en = 1'b1; b_invert = 1'b0; idle_level = 1'b0;
    wr_pat(6'b110101, 1'b1);
    pwm_wave = 1'b1; #2;
    check6("R9 example pwm hi", {drv_b, drv_a}, 6'b100111);
    pwm_wave = 1'b0; #2;
    check6("R9 example pwm lo", {drv_b, drv_a}, 6'b000000);
    idle_level = 1'b1; pwm_wave = 1'b0; #2;
    check6("R6 passive high", {drv_b, drv_a}, 6'b011000);
    idle_level = 1'b0;
  endtask

  task automatic t_binvert();
    mode_en = 1'b1; b_invert = 1'b1; idle_level = 1'b0; pwm_wave = 1'b1;
    wr_pat(6'b110101, 1'b1);
    #2;
    check6("R7 B inverted", {drv_b, drv_a}, 6'b011111);
    pwm_wave = 1'b0; #2;
    check6("R7 B inverted pwm lo", {drv_b, drv_a}, 6'b111000);
    b_invert = 1'b0;
  endtask

  task automatic t_bypass();
    mode_en = 1'b0; b_invert = 1'b1; idle_level = 1'b1; pwm_wave = 1'b1;
    norm_a = 3'b101; norm_b = 3'b010; #2;
    check6("R8 bypass 1", {drv_b, drv_a}, 6'b010101);
    norm_a = 3'b011; norm_b = 3'b110; pwm_wave = 1'b0; #2;
    check6("R8 bypass 2", {drv_b, drv_a}, 6'b110011);
    mode_en = 1'b1; b_invert = 1'b0; idle_level = 1'b0;
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 64; p++) begin
      wr_pat(6'(p), 1'b1);
      check6("R3 sweep active", pat_active, 6'(p));
      for (int c = 0; c < 8; c++) begin
        pwm_wave = c[0]; idle_level = c[1]; b_invert = c[2];
        check_outs("R5 R6 R7 R9 sweep");
      end
    end
    b_invert = 1'b0;
  endtask

  initial begin
    #4000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow_then_transfer();
    t_collide();
    t_example();
    t_binvert();
    t_bypass();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule